// File: doc/BRIEF.md
# Warp Instruction Issue Router

This block decides, once per clock, which instructions at the head of each warp's instruction buffer go to which execution pipeline. There are four typed pipelines: single-precision ALU (SP), double-precision (DP), special-function (SFU) and memory (MEM). Each scheduler presents up to `MAX_ISSUE` decoded instructions as an op class per slot, plus a valid bit per slot and a waiting flag for its warp. All schedulers share one free-slot count per pipeline, and every issue uses up one of those slots.

Several schedulers are serviced in a rotating order, starting from a priority index that advances by one every cycle. A scheduler serviced earlier uses up pipeline slots before a later one sees them. A parameter sets the number of DP units. When that number is zero, DP work is sent to the SFU pipe. A second parameter turns on a mode in which two instructions issued one after the other in the same cycle by the same scheduler may not go to the same pipeline type. The decisions are registered, so the issue strobes, pipeline selects and per-scheduler counts appear one cycle after the inputs they were computed from.

Top module: `wir_issue_router`

## Requirements
- R1: A load (op code 5) or store (op code 6) is sent to the MEM pipe (pipe code 4) when that pipe has a free slot. If it has none, the load or store does not issue.
- R2: A non-memory instruction whose op is neither SFU (2) nor DP (3) is sent to the SP pipe (pipe code 1) when SP has a free slot. This covers no-op (0), ALU (1) and ALU-or-SFU (4). The SP choice is tried before any DP or SFU choice.
- R3: With `NUM_DP_UNITS` nonzero, a DP op is sent to the DP pipe (pipe code 2) if DP has a free slot. Otherwise it does not issue.
- R4: With `NUM_DP_UNITS` zero, a DP op is handled like an SFU op, and pipe code 2 is never selected.
- R5: An SFU op, and an ALU-or-SFU op that did not get SP, is sent to the SFU pipe (pipe code 3) when SFU has a free slot.
- R6: With `DIFF_UNITS` set, an instruction may not go to the same pipe type as the instruction its own scheduler issued just before it in the same cycle. The record of that previous type starts empty for every scheduler in every cycle.
- R7: A scheduler issues nothing while its warp is waiting. Issue stops at the first slot that is invalid or cannot issue. A slot can issue only if every slot before it issued, and no more than `MAX_ISSUE` instructions issue per scheduler per cycle.
- R8: Each issue to a pipe uses up one of that pipe's free slots. Across all schedulers in one cycle, no pipe receives more instructions than its free count.
- R9: Schedulers are serviced in the order prio, prio+1, … modulo `NUM_SCHED`. The index prio advances by one, modulo `NUM_SCHED`, every cycle. A synchronous active-high reset sets it to 0.
- R10: The outputs change one clock edge after the inputs they depend on. A slot that does not fire shows pipe code 0. Each scheduler's count equals its number of fired slots. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_wait | input | NUM_SCHED | Per-scheduler warp waiting flag |
| slot_vld | input | NUM_SCHED*MAX_ISSUE | Slot valid; scheduler s, slot j at bit s*MAX_ISSUE+j |
| slot_op | input | NUM_SCHED*MAX_ISSUE*3 | Op class per slot, 3 bits each, same slot order |
| sp_free | input | FREE_W | Free slots in the SP pipe input register |
| dp_free | input | FREE_W | Free slots in the DP pipe input register |
| sfu_free | input | FREE_W | Free slots in the SFU pipe input register |
| mem_free | input | FREE_W | Free slots in the MEM pipe input register |
| iss_fire | output | NUM_SCHED*MAX_ISSUE | Registered issue strobe per slot |
| iss_pipe | output | NUM_SCHED*MAX_ISSUE*3 | Registered pipe code per slot |
| iss_cnt | output | NUM_SCHED*CNT_W | Registered issued count per scheduler |
| prio_idx | output | PRIO_W | Current rotating priority index |

## Verification
Two functions can act in the same cycle: the shared free-slot budget and the rotating priority, and the different-units rule and the SP-first order. To provoke the first pair, both schedulers offer only ALU work against two SP slots. The bench then checks that the scheduler named by the priority index seen at drive time takes both slots, that the other gets none, and that the roles swap in the next cycle. For the second pair, ALU-or-SFU pairs and same-type pairs are sent to the instance with the mode enabled. The bench checks that the second instruction moves to SFU or stalls, while the other scheduler's previous-type record starts empty in the same cycle.

// File: rtl/wir_pkg.sv
package wir_pkg;

    typedef enum logic [2:0] {
        OPC_NOP     = 3'd0,
        OPC_ALU     = 3'd1,
        OPC_SFU     = 3'd2,
        OPC_DP      = 3'd3,
        OPC_ALU_SFU = 3'd4,
        OPC_LOAD    = 3'd5,
        OPC_STORE   = 3'd6
    } opc_e;

    typedef enum logic [2:0] {
        PIPE_NONE = 3'd0,
        PIPE_SP   = 3'd1,
        PIPE_DP   = 3'd2,
        PIPE_SFU  = 3'd3,
        PIPE_MEM  = 3'd4
    } pipe_e;

    // free-slot vector order: index 0 SP, 1 DP, 2 SFU, 3 MEM (pipe code - 1)
    localparam int NUM_PIPES = 4;
    localparam int OPC_W     = 3;

endpackage

// File: rtl/wir_route_one.sv
module wir_route_one
    import wir_pkg::*;
#(
    parameter int NUM_DP_UNITS = 1,
    parameter int DIFF_UNITS   = 0
) (
    input  logic [OPC_W-1:0]     op,
    input  logic [NUM_PIPES-1:0] avail,
    input  logic [2:0]           prev,
    output logic [2:0]           tgt
);
    localparam bit HAS_DP  = (NUM_DP_UNITS != 0);
    localparam bit DIFF_ON = (DIFF_UNITS != 0);

    logic is_mem, ok_sp, ok_dp, ok_sfu, ok_mem, sfu_class;

    always_comb begin
        is_mem    = (op == OPC_LOAD) || (op == OPC_STORE);
        ok_sp     = !DIFF_ON || (prev != PIPE_SP);
        ok_dp     = !DIFF_ON || (prev != PIPE_DP);
        ok_sfu    = !DIFF_ON || (prev != PIPE_SFU);
        ok_mem    = !DIFF_ON || (prev != PIPE_MEM);
        sfu_class = (!HAS_DP && op == OPC_DP) || (op == OPC_SFU) || (op == OPC_ALU_SFU);
        tgt       = PIPE_NONE;
        if (is_mem) begin
            if (avail[3] && ok_mem) tgt = PIPE_MEM;
        end else if (avail[0] && op != OPC_SFU && op != OPC_DP && ok_sp) begin
            tgt = PIPE_SP;
        end else if (HAS_DP && op == OPC_DP && ok_dp) begin
            if (avail[1]) tgt = PIPE_DP;
        end else if (sfu_class && ok_sfu) begin
            if (avail[2]) tgt = PIPE_SFU;
        end
    end
endmodule

// File: rtl/wir_warp_issue.sv
module wir_warp_issue
    import wir_pkg::*;
#(
    parameter int MAX_ISSUE    = 2,
    parameter int FREE_W       = 2,
    parameter int NUM_DP_UNITS = 1,
    parameter int DIFF_UNITS   = 0,
    localparam int CNT_W       = $clog2(MAX_ISSUE + 1)
) (
    input  logic                          waiting,
    input  logic [MAX_ISSUE-1:0]          vld,
    input  logic [MAX_ISSUE*OPC_W-1:0]    ops,
    input  logic [NUM_PIPES*FREE_W-1:0]   free_in,
    output logic [MAX_ISSUE-1:0]          fire,
    output logic [MAX_ISSUE*3-1:0]        pipes,
    output logic [CNT_W-1:0]              cnt,
    output logic [NUM_PIPES*FREE_W-1:0]   free_out
);
    for (genvar j = 0; j < MAX_ISSUE; j++) begin : g_slot
        logic [NUM_PIPES*FREE_W-1:0] fr_in, fr_out;
        logic                        go_in, go_out;
        logic [2:0]                  prv_in, prv_out, tgt;
        logic [NUM_PIPES-1:0]        avail;
        logic                        take;

        if (j == 0) begin : g_head
            assign fr_in  = free_in;
            assign go_in  = !waiting;
            assign prv_in = PIPE_NONE;
        end else begin : g_link
            assign fr_in  = g_slot[j-1].fr_out;
            assign go_in  = g_slot[j-1].go_out;
            assign prv_in = g_slot[j-1].prv_out;
        end

        for (genvar k = 0; k < NUM_PIPES; k++) begin : g_pipe
            assign avail[k] = (fr_in[k*FREE_W +: FREE_W] != '0);
            assign fr_out[k*FREE_W +: FREE_W] =
                fr_in[k*FREE_W +: FREE_W] - FREE_W'(take && (tgt == 3'(k + 1)));
        end

        wir_route_one #(
            .NUM_DP_UNITS (NUM_DP_UNITS),
            .DIFF_UNITS   (DIFF_UNITS)
        ) u_route (
            .op    (ops[j*OPC_W +: OPC_W]),
            .avail (avail),
            .prev  (prv_in),
            .tgt   (tgt)
        );

        assign take             = go_in && vld[j] && (tgt != PIPE_NONE);
        assign go_out           = take;
        assign prv_out          = take ? tgt : prv_in;
        assign fire[j]          = take;
        assign pipes[j*3 +: 3]  = take ? tgt : PIPE_NONE;
    end

    assign free_out = g_slot[MAX_ISSUE-1].fr_out;

    always_comb begin
        cnt = '0;
        for (int j = 0; j < MAX_ISSUE; j++) cnt = cnt + CNT_W'(fire[j]);
    end
endmodule

// File: rtl/wir_prio_ring.sv
module wir_prio_ring #(
    parameter int NUM_SCHED = 2,
    localparam int PRIO_W   = (NUM_SCHED > 1) ? $clog2(NUM_SCHED) : 1
) (
    input  logic              clk,
    input  logic              rst,
    output logic [PRIO_W-1:0] prio
);
    logic [PRIO_W-1:0] prio_d, prio_q;

    always_comb begin
        prio_d = (int'(prio_q) == NUM_SCHED - 1) ? '0 : prio_q + PRIO_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) prio_q <= '0;
        else     prio_q <= prio_d;
    end

    assign prio = prio_q;

    // R9: index steps by one and wraps to zero
    p_prio_step_r9: assert property (@(posedge clk) disable iff (rst)
        (!rst && int'(prio_q) != NUM_SCHED - 1) |=> (int'(prio_q) == int'($past(prio_q)) + 1));
    p_prio_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (!rst && int'(prio_q) == NUM_SCHED - 1) |=> (prio_q == '0));
endmodule

// File: rtl/wir_issue_router.sv
module wir_issue_router
    import wir_pkg::*;
#(
    parameter int NUM_SCHED    = 2,
    parameter int MAX_ISSUE    = 2,
    parameter int FREE_W       = 2,
    parameter int NUM_DP_UNITS = 1,
    parameter int DIFF_UNITS   = 0,
    localparam int NM          = NUM_SCHED * MAX_ISSUE,
    localparam int CNT_W       = $clog2(MAX_ISSUE + 1),
    localparam int PRIO_W      = (NUM_SCHED > 1) ? $clog2(NUM_SCHED) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_SCHED-1:0]     warp_wait,
    input  logic [NM-1:0]            slot_vld,
    input  logic [NM*OPC_W-1:0]      slot_op,
    input  logic [FREE_W-1:0]        sp_free,
    input  logic [FREE_W-1:0]        dp_free,
    input  logic [FREE_W-1:0]        sfu_free,
    input  logic [FREE_W-1:0]        mem_free,
    output logic [NM-1:0]            iss_fire,
    output logic [NM*3-1:0]          iss_pipe,
    output logic [NUM_SCHED*CNT_W-1:0] iss_cnt,
    output logic [PRIO_W-1:0]        prio_idx
);
    typedef struct packed {
        logic [NM-1:0]              fire;
        logic [NM*3-1:0]            pipe;
        logic [NUM_SCHED*CNT_W-1:0] cnt;
    } out_t;

    out_t out_d, out_q;
    logic [PRIO_W-1:0] prio_q;
    logic [NUM_PIPES*FREE_W-1:0] free_all;

    logic [PRIO_W-1:0]    st_sel  [NUM_SCHED];
    logic [MAX_ISSUE-1:0] st_fire [NUM_SCHED];
    logic [MAX_ISSUE*3-1:0] st_pipe [NUM_SCHED];
    logic [CNT_W-1:0]     st_cnt  [NUM_SCHED];

    assign free_all = {mem_free, sfu_free, dp_free, sp_free};

    wir_prio_ring #(.NUM_SCHED(NUM_SCHED)) u_ring (
        .clk  (clk),
        .rst  (rst),
        .prio (prio_q)
    );

    // stage k services scheduler (prio + k) mod NUM_SCHED
    for (genvar k = 0; k < NUM_SCHED; k++) begin : g_stage
        logic [NUM_PIPES*FREE_W-1:0] fr_in, fr_out;

        if (k == 0) begin : g_head
            assign fr_in = free_all;
        end else begin : g_link
            assign fr_in = g_stage[k-1].fr_out;
        end

        assign st_sel[k] = PRIO_W'((int'(prio_q) + k) % NUM_SCHED);

        wir_warp_issue #(
            .MAX_ISSUE    (MAX_ISSUE),
            .FREE_W       (FREE_W),
            .NUM_DP_UNITS (NUM_DP_UNITS),
            .DIFF_UNITS   (DIFF_UNITS)
        ) u_warp (
            .waiting  (warp_wait[st_sel[k]]),
            .vld      (slot_vld[int'(st_sel[k])*MAX_ISSUE +: MAX_ISSUE]),
            .ops      (slot_op[int'(st_sel[k])*MAX_ISSUE*OPC_W +: MAX_ISSUE*OPC_W]),
            .free_in  (fr_in),
            .fire     (st_fire[k]),
            .pipes    (st_pipe[k]),
            .cnt      (st_cnt[k]),
            .free_out (fr_out)
        );
    end

    always_comb begin
        out_d = '0;
        for (int s = 0; s < NUM_SCHED; s++) begin
            for (int k = 0; k < NUM_SCHED; k++) begin
                if (int'(st_sel[k]) == s) begin
                    out_d.fire[s*MAX_ISSUE +: MAX_ISSUE]     = st_fire[k];
                    out_d.pipe[s*MAX_ISSUE*3 +: MAX_ISSUE*3] = st_pipe[k];
                    out_d.cnt[s*CNT_W +: CNT_W]              = st_cnt[k];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign iss_fire = out_q.fire;
    assign iss_pipe = out_q.pipe;
    assign iss_cnt  = out_q.cnt;
    assign prio_idx = prio_q;

    // ---------------- assertions ----------------
    localparam int NW = $clog2(NM + 1);
    logic [NW-1:0] n_q [NUM_PIPES];

    always_comb begin
        for (int p = 0; p < NUM_PIPES; p++) begin
            n_q[p] = '0;
            for (int i = 0; i < NM; i++)
                if (out_q.fire[i] && out_q.pipe[i*3 +: 3] == 3'(p + 1)) n_q[p] = n_q[p] + NW'(1);
        end
    end

    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_budget
        // R8: issued per pipe never exceeds the free count offered
        p_budget_r8: assert property (@(posedge clk) disable iff (rst)
            !rst |=> (int'(n_q[p]) <= int'($past(free_all[p*FREE_W +: FREE_W]))));
    end

    for (genvar i = 0; i < NM; i++) begin : g_slotchk
        // R10: a silent slot carries pipe code NONE, a fired one does not
        p_pipe_code_r10: assert property (@(posedge clk) disable iff (rst)
            out_q.fire[i] == (out_q.pipe[i*3 +: 3] != PIPE_NONE));
        if (i % MAX_ISSUE != 0) begin : g_order
            // R7: a slot fires only behind a fired predecessor
            p_in_order_r7: assert property (@(posedge clk) disable iff (rst)
                out_q.fire[i] |-> out_q.fire[i-1]);
            if (DIFF_UNITS != 0) begin : g_diff
                // R6: back-to-back issues differ in pipe type
                p_diff_unit_r6: assert property (@(posedge clk) disable iff (rst)
                    out_q.fire[i] |-> (out_q.pipe[i*3 +: 3] != out_q.pipe[(i-1)*3 +: 3]));
            end
        end
        if (NUM_DP_UNITS == 0) begin : g_nodp
            // R4: no DP unit means no DP selection
            p_no_dp_r4: assert property (@(posedge clk) disable iff (rst)
                out_q.pipe[i*3 +: 3] != PIPE_DP);
        end
    end

    for (genvar s = 0; s < NUM_SCHED; s++) begin : g_cntchk
        // R10: count agrees with fired strobes
        p_count_r10: assert property (@(posedge clk) disable iff (rst)
            int'(out_q.cnt[s*CNT_W +: CNT_W]) == $countones(out_q.fire[s*MAX_ISSUE +: MAX_ISSUE]));
    end
endmodule

// File: tb/sim_wir_issue_router.sv
`timescale 1ns/1ps
module sim_wir_issue_router;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  warp_wait = '0;
    logic [3:0]  slot_vld = '0;
    logic [11:0] slot_op = '0;
    logic [1:0]  sp_free = '0, dp_free = '0, sfu_free = '0, mem_free = '0;

    logic [3:0]  f0, f1;
    logic [11:0] p0, p1;
    logic [3:0]  c0, c1;
    logic        pr0, pr1;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // u0: one DP unit, different-units mode off
    wir_issue_router u0 (
        .clk(clk), .rst(rst), .warp_wait(warp_wait), .slot_vld(slot_vld), .slot_op(slot_op),
        .sp_free(sp_free), .dp_free(dp_free), .sfu_free(sfu_free), .mem_free(mem_free),
        .iss_fire(f0), .iss_pipe(p0), .iss_cnt(c0), .prio_idx(pr0)
    );

    // u1: no DP unit, different-units mode on
    wir_issue_router #(.NUM_DP_UNITS(0), .DIFF_UNITS(1)) u1 (
        .clk(clk), .rst(rst), .warp_wait(warp_wait), .slot_vld(slot_vld), .slot_op(slot_op),
        .sp_free(sp_free), .dp_free(dp_free), .sfu_free(sfu_free), .mem_free(mem_free),
        .iss_fire(f1), .iss_pipe(p1), .iss_cnt(c1), .prio_idx(pr1)
    );

    // row: wait vld op0 op1 sp dp sfu mem | fire pipe0 pipe1 cnt  (scheduler 0; scheduler 1 idle)
    localparam int ROWS = 13;
    localparam logic [26:0] TBL [ROWS] = '{
        {1'b0, 2'b11, 3'd1, 3'd1, 2'd2, 2'd0, 2'd0, 2'd0, 2'b11, 3'd1, 3'd1, 2'd2},
        {1'b0, 2'b11, 3'd1, 3'd1, 2'd1, 2'd0, 2'd0, 2'd0, 2'b01, 3'd1, 3'd0, 2'd1},
        {1'b0, 2'b11, 3'd3, 3'd2, 2'd0, 2'd1, 2'd1, 2'd0, 2'b11, 3'd2, 3'd3, 2'd2},
        {1'b0, 2'b11, 3'd3, 3'd1, 2'd2, 2'd0, 2'd0, 2'd0, 2'b00, 3'd0, 3'd0, 2'd0},
        {1'b0, 2'b11, 3'd5, 3'd6, 2'd0, 2'd0, 2'd0, 2'd1, 2'b01, 3'd4, 3'd0, 2'd1},
        {1'b0, 2'b11, 3'd4, 3'd4, 2'd1, 2'd0, 2'd1, 2'd0, 2'b11, 3'd1, 3'd3, 2'd2},
        {1'b0, 2'b11, 3'd2, 3'd1, 2'd2, 2'd0, 2'd0, 2'd0, 2'b00, 3'd0, 3'd0, 2'd0},
        {1'b1, 2'b11, 3'd1, 3'd1, 2'd2, 2'd0, 2'd0, 2'd0, 2'b00, 3'd0, 3'd0, 2'd0},
        {1'b0, 2'b01, 3'd1, 3'd1, 2'd2, 2'd0, 2'd0, 2'd0, 2'b01, 3'd1, 3'd0, 2'd1},
        {1'b0, 2'b10, 3'd1, 3'd1, 2'd2, 2'd0, 2'd0, 2'd0, 2'b00, 3'd0, 3'd0, 2'd0},
        {1'b0, 2'b11, 3'd0, 3'd5, 2'd1, 2'd0, 2'd0, 2'd1, 2'b11, 3'd1, 3'd4, 2'd2},
        {1'b0, 2'b11, 3'd3, 3'd3, 2'd0, 2'd2, 2'd0, 2'd0, 2'b11, 3'd2, 3'd2, 2'd2},
        {1'b0, 2'b11, 3'd6, 3'd5, 2'd0, 2'd0, 2'd0, 2'd2, 2'b11, 3'd4, 3'd4, 2'd2}
    };
    localparam string ROW_REQ [ROWS] = '{
        "R2", "R8", "R3", "R3", "R1", "R5", "R7", "R7", "R7", "R7", "R2", "R3", "R1"
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive0(input logic w, input logic [1:0] v, input logic [2:0] o0, input logic [2:0] o1,
                          input logic [1:0] sp, input logic [1:0] dp, input logic [1:0] sfu, input logic [1:0] mem);
        warp_wait = {1'b1, w};
        slot_vld  = {2'b00, v};
        slot_op   = {3'd0, 3'd0, o1, o0};
        sp_free = sp; dp_free = dp; sfu_free = sfu; mem_free = mem;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic p;
        repeat (3) @(negedge clk);
        // reset state: R10 outputs clear, R9 index zero
        check("R10", "reset fire", 32'(f0), 0);
        check("R10", "reset cnt", 32'(c0), 0);
        check("R9", "reset prio", 32'(pr0), 0);
        rst = 1'b0;
        check("R9", "prio after release", 32'(pr0), 0);
        step();
        check("R9", "prio step", 32'(pr0), 1);
        step();
        check("R9", "prio wrap", 32'(pr0), 0);

        // table walk on u0
        for (int r = 0; r < ROWS; r++) begin
            logic [26:0] row;
            row = TBL[r];
            drive0(row[26], row[25:24], row[23:21], row[20:18],
                   row[17:16], row[15:14], row[13:12], row[11:10]);
            step();
            check(ROW_REQ[r], $sformatf("row %0d fire", r), 32'(f0[1:0]), 32'(row[9:8]));
            check(ROW_REQ[r], $sformatf("row %0d pipe0", r), 32'(p0[2:0]), 32'(row[7:5]));
            check(ROW_REQ[r], $sformatf("row %0d pipe1", r), 32'(p0[5:3]), 32'(row[4:2]));
            check(ROW_REQ[r], $sformatf("row %0d cnt", r), 32'(c0[1:0]), 32'(row[1:0]));
            check("R7", $sformatf("row %0d idle sched", r), 32'(f0[3:2]), 0);
        end

        // R4 and R3: DP pair with no DP slots, two SFU slots
        drive0(1'b0, 2'b11, 3'd3, 3'd3, 2'd0, 2'd0, 2'd2, 2'd0);
        step();
        check("R4", "u1 DP to SFU fire", 32'(f1[1:0]), 32'b01);
        check("R4", "u1 DP to SFU pipe", 32'(p1[5:0]), {26'd0, 3'd0, 3'd3});
        check("R3", "u0 DP stalls without DP slot", 32'(f0[1:0]), 0);

        // R6: same-type ALU pair with diff mode
        drive0(1'b0, 2'b11, 3'd1, 3'd1, 2'd2, 2'd0, 2'd0, 2'd0);
        step();
        check("R6", "u1 ALU pair fire", 32'(f1[1:0]), 32'b01);
        check("R6", "u1 ALU pair cnt", 32'(c1[1:0]), 1);
        check("R6", "u0 ALU pair fire", 32'(f0[1:0]), 32'b11);

        // R6 with R5: ALU-or-SFU second moves to SFU
        drive0(1'b0, 2'b11, 3'd4, 3'd4, 2'd2, 2'd0, 2'd1, 2'd0);
        step();
        check("R6", "u1 ALU-or-SFU pipes", 32'(p1[5:0]), {26'd0, 3'd3, 3'd1});
        check("R2", "u0 ALU-or-SFU pipes", 32'(p0[5:0]), {26'd0, 3'd1, 3'd1});

        // R4: DP then ALU on u1
        drive0(1'b0, 2'b11, 3'd3, 3'd1, 2'd1, 2'd0, 2'd1, 2'd0);
        step();
        check("R4", "u1 DP then ALU pipes", 32'(p1[5:0]), {26'd0, 3'd1, 3'd3});

        // R6: two memory ops in diff mode
        drive0(1'b0, 2'b11, 3'd5, 3'd6, 2'd0, 2'd0, 2'd0, 2'd2);
        step();
        check("R6", "u1 mem pair fire", 32'(f1[1:0]), 32'b01);

        // R9 with R8: both schedulers contend for two SP slots
        for (int n = 0; n < 2; n++) begin
            warp_wait = 2'b00;
            slot_vld  = 4'b1111;
            slot_op   = {3'd1, 3'd1, 3'd1, 3'd1};
            sp_free = 2'd2; dp_free = 2'd0; sfu_free = 2'd0; mem_free = 2'd0;
            p = pr0;
            step();
            check("R9", "winner fire", p ? 32'(f0[3:2]) : 32'(f0[1:0]), 32'b11);
            check("R8", "loser fire", p ? 32'(f0[1:0]) : 32'(f0[3:2]), 0);
            check("R6", "u1 per-sched prev reset", 32'(f1), 32'b0101);
        end

        // R8: one SP slot shared
        sp_free = 2'd1;
        p = pr0;
        step();
        check("R8", "single slot winner", p ? 32'(f0[3:2]) : 32'(f0[1:0]), 32'b01);
        check("R8", "single slot loser", p ? 32'(f0[1:0]) : 32'(f0[3:2]), 0);

        // mid-run reset
        sp_free = 2'd2;
        rst = 1'b1;
        step();
        check("R10", "reset clears fire", 32'(f0), 0);
        check("R9", "reset clears prio", 32'(pr0), 0);
        rst = 1'b0;
        step();
        check("R10", "after reset fire", 32'(f0), 32'b0011);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule